// File: doc/BRIEF.md
# Multi-Queue First-Word-Fall-Through Buffer

This block holds 36-bit words in up to 32 logical queues that share one memory, and each queue has an equal fixed slice of that memory. The write side and the read side each run on their own clock. Each side selects its queue with an address strobe. The address carries a device field in its upper bits and a queue number in its lower bits. A write enable appends the write data to the selected write queue. On the read side the head word of the selected queue falls through to the output without a request. An active-low flag, `fresh_n`, tells whether the word on the output is new (low) or has already been consumed (high).

Several of these blocks can share one output bus. A block owns the bus after a read strobe whose device field matches its own identifier. The `bus_own` output qualifies `rd_data` and `fresh_n`, so that the pads can be put in high impedance when the block does not own the bus.

A read queue switch has a fixed pipeline:
- Two read clocks after the strobe, the first word of the new queue is fetched onto the output.
- One read clock later, the flag shows whether that word exists.

When a queue is read to empty, its last word stays on the output with the flag high. A later write into that queue brings the word out without a read request, after the two-flop crossing into the read clock domain.

Top module: `mq_fwft_buffer`

## Requirements
- R1: After reset `fresh_n` is 1, `bus_own` is 0, and every queue is empty.
- R2: Each queue holds at most SLOTS words (8 by default). A write to a full queue is dropped and does not disturb the words already stored.
- R3: A read strobe is sampled on a read clock edge with `rsel_addr` = {device field (upper DEV_W bits), queue number (lower bits)}. From that edge on, `bus_own` is 1 exactly when the device field equals DEV_ID (default 0).
- R4: On a switch to a non-empty queue, the head word of that queue appears on `rd_data` after the second read clock edge following the strobe edge, with no `ren`. Across the strobe edge and the next two edges, `fresh_n` keeps its previous value.
- R5: After the third read clock edge following the strobe edge, `fresh_n` is 0 if a word was fetched. If the new queue was empty, `fresh_n` is 1 and `rd_data` keeps its previous word.
- R6: A read edge with `fresh_n` = 0 and `ren` = 1 consumes the shown word. If the queue holds another word, that word is shown and `fresh_n` stays 0. If the queue is empty, `fresh_n` goes to 1 and the last word stays on `rd_data`. With `ren` = 0, the output does not change.
- R7: `ren` has no effect while `fresh_n` is 1 or during a queue switch. No word is consumed or lost by such a read.
- R8: While the selected read queue is empty and `fresh_n` is 1, a write into that queue shows the word with `fresh_n` = 0 after the third read clock edge following the write edge, when both clocks are the same. The three edges are two synchronizer flops plus one load.
- R9: Queues are independent. Each one returns its words in write order, whatever writes and reads go to other queues in between.
- R10: A write strobe with a device field other than DEV_ID disables writes, and words written while it is in force are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write side clock |
| rclk | input | 1 | Read side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wsel_en | input | 1 | Write queue address strobe |
| wsel_addr | input | DEV_W+log2(QUEUES) | Device field and queue number for writes |
| wen | input | 1 | Write enable, appends `wdata` to the write queue |
| wdata | input | WORD_W | Write data |
| rsel_en | input | 1 | Read queue address strobe |
| rsel_addr | input | DEV_W+log2(QUEUES) | Device field and queue number for reads |
| ren | input | 1 | Read enable, consumes the shown word |
| rd_data | output | WORD_W | Output word |
| fresh_n | output | 1 | Active low: 0 means `rd_data` is new and valid |
| bus_own | output | 1 | High while this block drives the shared output bus |

## Verification
Each result is checked in a fixed cycle counted from the edge that sampled its stimulus:
- `bus_own` one read edge after the strobe.
- The fetched word two edges after the strobe, while the flag is still unchanged.
- The flag three edges after the strobe.
- The next word or the stale flag one edge after a read.
- The auto-loaded word three edges after a write into the empty selected queue.

The bench drives inputs and samples outputs on the falling clock edge, and it counts edges explicitly in each task. Both clock ports are driven from one clock, which fixes the crossing latency. Random write bursts are issued while reads are parked on another device. The bench then idles until the crossings settle and drains one queue with random gaps, checking each word against a per-queue model.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int WORD_W_DEF = 36;
    localparam int QUEUES_DEF = 32;
    localparam int SLOTS_DEF  = 8;

    // read-side switch pipeline, counted down from SETTLE to RUN
    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_REVEAL = 2'd1,
        PH_FETCH  = 2'd2,
        PH_SETTLE = 2'd3
    } rd_phase_e;
endpackage

// File: rtl/mq_ptr_sync.sv
module mq_ptr_sync #(
    parameter int W = 8
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/mq_ram.sv
module mq_ram #(
    parameter int WORD_W = 36,
    parameter int AW     = 8,
    localparam int DEPTH = 1 << AW
)(
    input  logic              wclk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mq_wr_ctrl.sv
module mq_wr_ctrl #(
    parameter int QUEUES = 32,
    parameter int SLOTS  = 8,
    localparam int QAW = $clog2(QUEUES),
    localparam int SW  = $clog2(SLOTS),
    localparam int PW  = SW + 1
)(
    input  logic                       wclk,
    input  logic                       rst_n,
    input  logic                       sel_en,
    input  logic [QAW-1:0]             sel_q,
    input  logic                       sel_hit,
    input  logic                       wen,
    input  logic [QUEUES-1:0][PW-1:0]  rgray_s,
    output logic                       we,
    output logic [QAW+SW-1:0]          waddr,
    output logic [QUEUES-1:0][PW-1:0]  wgray
);
    typedef struct packed {
        logic [QAW-1:0]            q;
        logic                      act;
        logic [QUEUES-1:0][PW-1:0] ptr;
        logic [QUEUES-1:0][PW-1:0] gray;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] rbin, fill;
    logic          full;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d  = st_q;
        rbin  = g2b(rgray_s[st_q.q]);
        fill  = st_q.ptr[st_q.q] - rbin;
        full  = (fill == PW'(SLOTS));
        we    = st_q.act && wen && !full;
        waddr = {st_q.q, st_q.ptr[st_q.q][SW-1:0]};
        if (we) st_d.ptr[st_q.q] = st_q.ptr[st_q.q] + PW'(1);
        if (sel_en) begin
            st_d.q   = sel_q;
            st_d.act = sel_hit;
        end
        for (int i = 0; i < QUEUES; i++)
            st_d.gray[i] = st_d.ptr[i] ^ (st_d.ptr[i] >> 1);
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wgray = st_q.gray;

    // R2: the selected queue never holds more than its slice
    assert_no_overflow_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        fill <= PW'(SLOTS))
        else $error("queue fill above capacity");

    // R2: a write attempt on a full queue leaves every pointer untouched
    assert_full_drops_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        (st_q.act && wen && full) |=> (st_q.ptr == $past(st_q.ptr)))
        else $error("write into full queue moved a pointer");

    // R10: a write with no selected queue of this device changes nothing
    assert_foreign_write_R10: assert property (@(posedge wclk) disable iff (!rst_n)
        (!st_q.act) |=> (st_q.ptr == $past(st_q.ptr)))
        else $error("write for another device stored data");
endmodule

// File: rtl/mq_rd_ctrl.sv
module mq_rd_ctrl #(
    parameter int WORD_W = 36,
    parameter int QUEUES = 32,
    parameter int SLOTS  = 8,
    localparam int QAW = $clog2(QUEUES),
    localparam int SW  = $clog2(SLOTS),
    localparam int PW  = SW + 1
)(
    input  logic                       rclk,
    input  logic                       rst_n,
    input  logic                       sel_en,
    input  logic [QAW-1:0]             sel_q,
    input  logic                       sel_hit,
    input  logic                       ren,
    input  logic [QUEUES-1:0][PW-1:0]  wgray_s,
    input  logic [WORD_W-1:0]          rdata,
    output logic [QAW+SW-1:0]          raddr,
    output logic [QUEUES-1:0][PW-1:0]  rgray,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       fresh_n,
    output logic                       bus_own
);
    import mq_pkg::*;

    typedef struct packed {
        rd_phase_e                 phase;
        logic [QAW-1:0]            q;
        logic                      own;
        logic                      have;
        logic                      fresh_n;
        logic [WORD_W-1:0]         word;
        logic [QUEUES-1:0][PW-1:0] ptr;
        logic [QUEUES-1:0][PW-1:0] gray;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [PW-1:0] wbin;
    logic          avail, take;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d  = st_q;
        take  = 1'b0;
        wbin  = g2b(wgray_s[st_q.q]);
        avail = (wbin != st_q.ptr[st_q.q]);
        raddr = {st_q.q, st_q.ptr[st_q.q][SW-1:0]};
        case (st_q.phase)
            PH_SETTLE: st_d.phase = PH_FETCH;
            PH_FETCH: begin
                take       = st_q.own && avail;
                st_d.have  = st_q.own && avail;
                st_d.phase = PH_REVEAL;
            end
            PH_REVEAL: begin
                st_d.fresh_n = !st_q.have;
                st_d.phase   = PH_RUN;
            end
            default: begin
                if (st_q.own) begin
                    if (!st_q.fresh_n && ren) begin
                        if (avail) take = 1'b1;
                        else       st_d.fresh_n = 1'b1;
                    end else if (st_q.fresh_n && avail) begin
                        take         = 1'b1;
                        st_d.fresh_n = 1'b0;
                    end
                end
            end
        endcase
        if (take) begin
            st_d.word        = rdata;
            st_d.ptr[st_q.q] = st_q.ptr[st_q.q] + PW'(1);
        end
        if (sel_en) begin
            st_d.q     = sel_q;
            st_d.own   = sel_hit;
            st_d.phase = PH_SETTLE;
        end
        for (int i = 0; i < QUEUES; i++)
            st_d.gray[i] = st_d.ptr[i] ^ (st_d.ptr[i] >> 1);
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.phase   <= PH_RUN;
            st_q.fresh_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgray   = st_q.gray;
    assign rd_data = st_q.word;
    assign fresh_n = st_q.fresh_n;
    assign bus_own = st_q.own;

    // R3: ownership follows the device field of the last read strobe
    assert_bus_owner_R3: assert property (@(posedge rclk) disable iff (!rst_n)
        sel_en |=> (st_q.own == $past(sel_hit)))
        else $error("bus ownership not taken from strobe");

    // R4: the flag is frozen during the first two edges of a switch
    assert_switch_flag_hold_R4: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q.phase == PH_SETTLE || st_q.phase == PH_FETCH) |=> $stable(st_q.fresh_n))
        else $error("flag moved early in a switch");

    // R6: reading the last word marks it stale and keeps it on the bus
    assert_last_word_stays_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && st_q.own && !st_q.fresh_n && ren && !avail)
        |=> (st_q.fresh_n && $stable(st_q.word)))
        else $error("last word not held as stale");

    // R7: with nothing stored, a stale flag stays high whatever ren does
    assert_stale_read_ignored_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && st_q.fresh_n && !avail && !sel_en)
        |=> (st_q.fresh_n && $stable(st_q.word)))
        else $error("read while stale changed the output");
endmodule

// File: rtl/mq_fwft_buffer.sv
module mq_fwft_buffer #(
    parameter int WORD_W = mq_pkg::WORD_W_DEF,
    parameter int QUEUES = mq_pkg::QUEUES_DEF,
    parameter int SLOTS  = mq_pkg::SLOTS_DEF,
    parameter int DEV_W  = 2,
    parameter int DEV_ID = 0,
    localparam int QAW    = $clog2(QUEUES),
    localparam int ADDR_W = DEV_W + QAW
)(
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wsel_en,
    input  logic [ADDR_W-1:0] wsel_addr,
    input  logic              wen,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rsel_en,
    input  logic [ADDR_W-1:0] rsel_addr,
    input  logic              ren,
    output logic [WORD_W-1:0] rd_data,
    output logic              fresh_n,
    output logic              bus_own
);
    localparam int SW = $clog2(SLOTS);
    localparam int PW = SW + 1;
    localparam int GW = QUEUES * PW;
    localparam int AW = QAW + SW;

    logic                      w_hit, r_hit, we;
    logic [AW-1:0]             waddr, raddr;
    logic [WORD_W-1:0]         rdata;
    logic [QUEUES-1:0][PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [GW-1:0]             wg_flat, rg_flat, wg_sync, rg_sync;

    assign w_hit   = (wsel_addr[ADDR_W-1:QAW] == DEV_W'(DEV_ID));
    assign r_hit   = (rsel_addr[ADDR_W-1:QAW] == DEV_W'(DEV_ID));
    assign wg_flat = wgray;
    assign rg_flat = rgray;
    assign wgray_s = wg_sync;
    assign rgray_s = rg_sync;

    mq_wr_ctrl #(.QUEUES(QUEUES), .SLOTS(SLOTS)) u_wr (
        .wclk    (wclk),
        .rst_n   (rst_n),
        .sel_en  (wsel_en),
        .sel_q   (wsel_addr[QAW-1:0]),
        .sel_hit (w_hit),
        .wen     (wen),
        .rgray_s (rgray_s),
        .we      (we),
        .waddr   (waddr),
        .wgray   (wgray)
    );

    mq_ptr_sync #(.W(GW)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wg_flat),
        .q     (wg_sync)
    );

    mq_ptr_sync #(.W(GW)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rg_flat),
        .q     (rg_sync)
    );

    mq_ram #(.WORD_W(WORD_W), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    mq_rd_ctrl #(.WORD_W(WORD_W), .QUEUES(QUEUES), .SLOTS(SLOTS)) u_rd (
        .rclk    (rclk),
        .rst_n   (rst_n),
        .sel_en  (rsel_en),
        .sel_q   (rsel_addr[QAW-1:0]),
        .sel_hit (r_hit),
        .ren     (ren),
        .wgray_s (wgray_s),
        .rdata   (rdata),
        .raddr   (raddr),
        .rgray   (rgray),
        .rd_data (rd_data),
        .fresh_n (fresh_n),
        .bus_own (bus_own)
    );
endmodule

// File: tb/sim_mq_fwft_buffer.sv
module sim_mq_fwft_buffer;
    localparam int NQ = 32;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wsel_en = 1'b0, wen = 1'b0, rsel_en = 1'b0, ren = 1'b0;
    logic [6:0]  wsel_addr = '0, rsel_addr = '0;
    logic [35:0] wdata = '0;
    logic [35:0] rd_data;
    logic        fresh_n, bus_own;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [35:0] mdl [NQ][NS];
    int hd [NQ];
    int cnt [NQ];
    int wq_m = 0, wdev_m = 0, rq_m = 0;
    bit own_m = 1'b0, mov = 1'b1;
    logic [35:0] shown = '0;

    always #5 clk = ~clk;

    mq_fwft_buffer u0 (
        .wclk(clk), .rclk(clk), .rst_n(rst_n),
        .wsel_en(wsel_en), .wsel_addr(wsel_addr), .wen(wen), .wdata(wdata),
        .rsel_en(rsel_en), .rsel_addr(rsel_addr), .ren(ren),
        .rd_data(rd_data), .fresh_n(fresh_n), .bus_own(bus_own)
    );

    function automatic bit m_push(int q, logic [35:0] w);
        if (cnt[q] >= NS) return 1'b0;
        mdl[q][(hd[q] + cnt[q]) % NS] = w;
        cnt[q] = cnt[q] + 1;
        return 1'b1;
    endfunction

    function automatic logic [35:0] m_pop(int q);
        logic [35:0] w;
        w = mdl[q][hd[q]];
        hd[q] = (hd[q] + 1) % NS;
        cnt[q] = cnt[q] - 1;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_select(input int dev, input int q);
        wsel_addr = {2'(dev), 5'(q)};
        wsel_en = 1'b1;
        @(negedge clk);
        wsel_en = 1'b0;
        wq_m = q; wdev_m = dev;
    endtask

    task automatic wr_push(input logic [35:0] w);
        bit acc;
        wdata = w; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
        if (wdev_m == 0) acc = m_push(wq_m, w);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe sampled at edge k; ren optionally high on edges k+1 and k+2
    task automatic rd_select(input int dev, input int q, input bit ren_during);
        logic        p_ov;
        logic [35:0] p_dout, exp;
        bit          got;
        p_ov = fresh_n; p_dout = rd_data;
        rsel_addr = {2'(dev), 5'(q)};
        rsel_en = 1'b1;
        @(negedge clk);                       // after edge k
        rsel_en = 1'b0;
        ren = ren_during;
        chk(bus_own === (dev == 0), "R3 bus_own", 36'(bus_own), 36'(dev == 0));
        own_m = (dev == 0); rq_m = q;
        @(negedge clk);                       // after edge k+1
        @(negedge clk);                       // after edge k+2
        ren = 1'b0;
        if (!own_m) begin
            idle(1);
            return;
        end
        got = (cnt[q] > 0);
        if (got) begin
            exp = m_pop(q);
            chk(rd_data === exp, "R4 fetched word", rd_data, exp);
            shown = exp;
        end else begin
            chk(rd_data === p_dout, "R5 empty switch keeps word", rd_data, p_dout);
        end
        chk(fresh_n === p_ov, "R4 flag held in switch", 36'(fresh_n), 36'(p_ov));
        @(negedge clk);                       // after edge k+3
        chk(fresh_n === !got, "R5 flag after switch", 36'(fresh_n), 36'(!got));
        mov = !got;
    endtask

    task automatic rd_next();
        logic [35:0] exp;
        ren = 1'b1;
        @(negedge clk);
        ren = 1'b0;
        if (mov) begin
            chk(fresh_n === 1'b1 && rd_data === shown, "R7 read while stale", rd_data, shown);
        end else if (cnt[rq_m] > 0) begin
            exp = m_pop(rq_m);
            chk(fresh_n === 1'b0 && rd_data === exp, "R6 next word", rd_data, exp);
            shown = exp;
        end else begin
            chk(fresh_n === 1'b1 && rd_data === shown, "R6 last word stale", rd_data, shown);
            mov = 1'b1;
        end
    endtask

    initial begin
        int seed_v;
        int got_words;
        logic [35:0] w;
        seed_v = $urandom(20250611);
        for (int i = 0; i < NQ; i++) begin hd[i] = 0; cnt[i] = 0; end
        idle(4);
        // R1: reset state
        chk(fresh_n === 1'b1, "R1 flag at reset", 36'(fresh_n), 36'd1);
        chk(bus_own === 1'b0, "R1 bus released at reset", 36'(bus_own), 36'd0);
        rst_n = 1'b1;
        idle(2);

        // park reads on another device, fill queue 5
        rd_select(1, 0, 1'b0);
        wr_select(0, 5);
        for (int i = 0; i < 3; i++) wr_push(36'h500000000 + 36'(i));
        idle(4);
        rd_select(0, 5, 1'b0);
        for (int i = 0; i < 3; i++) rd_next();
        rd_next();                            // R7: ren while stale

        // R8: write into the empty, selected queue
        w = 36'hABCDE1234;
        wdata = w; wen = 1'b1;
        @(negedge clk);                       // after write edge e
        wen = 1'b0;
        chk(fresh_n === 1'b1, "R8 flag after e", 36'(fresh_n), 36'd1);
        @(negedge clk);
        chk(fresh_n === 1'b1, "R8 flag after e+1", 36'(fresh_n), 36'd1);
        @(negedge clk);
        chk(fresh_n === 1'b1, "R8 flag after e+2", 36'(fresh_n), 36'd1);
        @(negedge clk);
        chk(fresh_n === 1'b0 && rd_data === w, "R8 auto-loaded word", rd_data, w);
        mov = 1'b0; shown = w;
        rd_next();

        // R2: overfill queue 9, R7: ren held during the switch
        rd_select(1, 0, 1'b0);
        wr_select(0, 9);
        for (int i = 0; i < 10; i++) wr_push(36'h900000000 + 36'(i));
        idle(4);
        rd_select(0, 9, 1'b1);
        got_words = mov ? 0 : 1;
        while (!mov) begin
            rd_next();
            if (!mov) got_words++;
        end
        chk(got_words == NS, "R2 words kept in full queue", 36'(got_words), 36'(NS));

        // R10: writes aimed at another device are dropped
        wr_select(1, 4);
        wr_push(36'h444444444);
        wr_push(36'h444444445);
        idle(4);
        rd_select(0, 4, 1'b0);
        chk(fresh_n === 1'b1, "R10 foreign write discarded", 36'(fresh_n), 36'd1);

        // R9: switching away keeps the rest of a queue
        rd_select(1, 0, 1'b0);
        wr_select(0, 7);
        wr_push(36'h700000001);
        wr_push(36'h700000002);
        wr_select(0, 3);
        idle(4);
        rd_select(0, 7, 1'b0);
        rd_select(0, 3, 1'b0);
        rd_select(0, 7, 1'b0);
        chk(rd_data === 36'h700000002, "R9 queue resumes in order", rd_data, 36'h700000002);
        rd_next();

        // constrained random bursts
        for (int it = 0; it < 40; it++) begin
            int nw, q;
            rd_select(1, 0, 1'b0);
            nw = int'($urandom % 12);
            for (int k = 0; k < nw; k++) begin
                if (k == 0 || ($urandom % 3) == 0)
                    wr_select((($urandom % 8) == 0) ? 1 : 0, int'($urandom % 6));
                wr_push({$urandom, 4'($urandom)});
            end
            idle(4);
            q = int'($urandom % 6);
            rd_select(0, q, 1'($urandom % 2));
            while (!mov) begin
                if (($urandom % 3) == 0) begin
                    @(negedge clk);
                    chk(fresh_n === 1'b0 && rd_data === shown, "R6 hold without ren", rd_data, shown);
                end else begin
                    rd_next();
                end
            end
            chk(cnt[q] == 0, "R9 queue drained", 36'(cnt[q]), 36'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule